// File: doc/BRIEF.md
# Trapped Instruction Condition Checker

This block decides whether an instruction that trapped should in fact have executed. It takes two 32-bit words: the exception syndrome captured at the trap and the saved processor status word. From them it produces one pass/fail bit. Pass means the instruction's condition held. Fail means the instruction should be treated as a no-op.

The condition code comes from one of two places. If the syndrome flags its condition field as valid, the code is read from that field. Otherwise the code is rebuilt from the if-then block state kept in the status word. The chosen code is then tested against the N, Z, C and V flags. The test uses a 16-by-16 mask table, which the block computes from the flag equations at elaboration time.

Each request presented with `in_valid` produces one registered result, one clock later.

Top module: `trap_cond_check`

## Requirements
- R1: When syndrome bits 31:30 are not both zero, the result is pass, whatever the other inputs are.
- R2: When syndrome bits 31:30 are zero and syndrome bit 24 (condition valid) is 1, the condition code is syndrome bits 23:20. A code of 0xE gives pass.
- R3: On the syndrome path, codes other than 0xE are tested against the flag nibble. The nibble is status bits 31:28, ordered as N at bit 31, Z at bit 30, C at bit 29 and V at bit 28. The codes are: 0 Z set, 1 Z clear, 2 C set, 3 C clear, 4 N set, 5 N clear, 6 V set, 7 V clear, 8 C set and Z clear, 9 C clear or Z set, 10 N equals V, 11 N differs from V, 12 Z clear and N equals V, 13 Z set or N differs from V, 14 always, 15 never.
- R4: When syndrome bits 31:30 are zero and bit 24 is 0, an 8-bit if-then state is formed. Its upper six bits are status bits 15:10 and its lower two bits are status bits 26:25. A zero state gives pass.
- R5: When that if-then state is nonzero, the condition code is its upper four bits, which are status bits 15:12. The code is tested with the same meanings as in R3.
- R6: A tested condition code of 0xF never passes, on either source path.
- R7: `out_valid` is `in_valid` delayed by one clock. `out_pass` carries the result for the request accepted on that edge. Reset clears both outputs to 0.
- R8: While `in_valid` is low, `out_pass` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A request is present on this cycle |
| syndrome | input | 32 | Exception syndrome word of the trapped instruction |
| status | input | 32 | Saved processor status word: flags and if-then state |
| out_valid | output | 1 | Registered result is valid |
| out_pass | output | 1 | 1 when the instruction should have executed |

## Verification
The assertions check several rules on every cycle: the one-cycle valid timing, the hold of `out_pass` while idle, the forced passes for an unconditional syndrome, for code 0xE and for an empty if-then state, and the never-pass code 0xF. They cannot show that each of the other fourteen codes reads the right flags, or that the right status bits feed the if-then code. Only the bench's scenarios show those: full sweeps of every code against all sixteen flag values on both source paths, checked against a reference built from the flag equations, plus seeded random words.

// File: rtl/tcc_pkg.sv
`timescale 1ns/1ps
package tcc_pkg;
    localparam int unsigned NUM_COND  = 16;
    localparam int unsigned NUM_FLAGS = 16;
    localparam int unsigned COND_W    = $clog2(NUM_COND);
    localparam int unsigned IT_W      = 8;

    // syndrome field positions
    localparam int unsigned SYN_CLASS_HI = 31;
    localparam int unsigned SYN_CLASS_LO = 30;
    localparam int unsigned SYN_CV_POS   = 24;
    localparam int unsigned SYN_COND_LO  = 20;

    // status field positions
    localparam int unsigned ST_FLAG_LO = 28;
    localparam int unsigned ST_ITH_HI  = 15;
    localparam int unsigned ST_ITH_LO  = 10;
    localparam int unsigned ST_ITL_HI  = 26;
    localparam int unsigned ST_ITL_LO  = 25;

    typedef enum logic [COND_W-1:0] {
        CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
        CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
        CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
        CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic [1:0] {
        SRC_UNCOND  = 2'd0,
        SRC_SYND    = 2'd1,
        SRC_ITIDLE  = 2'd2,
        SRC_ITSTATE = 2'd3
    } src_e;

    typedef struct packed {
        src_e  src;
        logic  force_pass;
        cond_e cond;
    } decision_t;

    function automatic logic cond_holds(cond_e code, flags_t f);
        logic r;
        unique case (code)
            CC_EQ: r = f.z;
            CC_NE: r = !f.z;
            CC_CS: r = f.c;
            CC_CC: r = !f.c;
            CC_MI: r = f.n;
            CC_PL: r = !f.n;
            CC_VS: r = f.v;
            CC_VC: r = !f.v;
            CC_HI: r = f.c && !f.z;
            CC_LS: r = !f.c || f.z;
            CC_GE: r = (f.n == f.v);
            CC_LT: r = (f.n != f.v);
            CC_GT: r = !f.z && (f.n == f.v);
            CC_LE: r = f.z || (f.n != f.v);
            CC_AL: r = 1'b1;
            CC_NV: r = 1'b0;
            default: r = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/tcc_source_sel.sv
`timescale 1ns/1ps
module tcc_source_sel
    import tcc_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic [WORD_W-1:0] syndrome,
    input  logic [WORD_W-1:0] status,
    output decision_t         decision
);
    logic [IT_W-1:0]   it_state;
    logic [COND_W-1:0] syn_code;
    logic              syn_uncond;
    logic              syn_cv;

    assign it_state   = {status[ST_ITH_HI:ST_ITH_LO], status[ST_ITL_HI:ST_ITL_LO]};
    assign syn_code   = syndrome[SYN_COND_LO +: COND_W];
    assign syn_uncond = |syndrome[SYN_CLASS_HI:SYN_CLASS_LO];
    assign syn_cv     = syndrome[SYN_CV_POS];

    always_comb begin
        decision.src        = SRC_UNCOND;
        decision.force_pass = 1'b1;
        decision.cond       = CC_AL;
        if (syn_uncond) begin
            decision.src        = SRC_UNCOND;
            decision.force_pass = 1'b1;
        end else if (syn_cv) begin
            decision.src        = SRC_SYND;
            decision.cond       = cond_e'(syn_code);
            decision.force_pass = (cond_e'(syn_code) == CC_AL);
        end else if (it_state == '0) begin
            decision.src        = SRC_ITIDLE;
            decision.force_pass = 1'b1;
        end else begin
            decision.src        = SRC_ITSTATE;
            decision.cond       = cond_e'(it_state[IT_W-1 -: COND_W]);
            decision.force_pass = 1'b0;
        end
    end
endmodule

// File: rtl/tcc_mask_table.sv
`timescale 1ns/1ps
module tcc_mask_table
    import tcc_pkg::*;
(
    output logic [NUM_COND-1:0][NUM_FLAGS-1:0] mask
);
    for (genvar gc = 0; gc < NUM_COND; gc++) begin : g_cond
        for (genvar gf = 0; gf < NUM_FLAGS; gf++) begin : g_flag
            assign mask[gc][gf] = cond_holds(cond_e'(COND_W'(gc)), flags_t'(4'(gf)));
        end
    end
endmodule

// File: rtl/tcc_evaluate.sv
`timescale 1ns/1ps
module tcc_evaluate
    import tcc_pkg::*;
(
    input  decision_t                         decision,
    input  flags_t                            flags,
    input  logic [NUM_COND-1:0][NUM_FLAGS-1:0] mask,
    output logic                              pass
);
    logic [NUM_FLAGS-1:0] row;
    assign row  = mask[decision.cond];
    assign pass = decision.force_pass | row[flags];
endmodule

// File: rtl/tcc_out_reg.sv
`timescale 1ns/1ps
module tcc_out_reg (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic pass,
    output logic out_valid,
    output logic out_pass
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pass  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_pass <= pass;
            end
        end
    end
endmodule

// File: rtl/trap_cond_check.sv
`timescale 1ns/1ps
module trap_cond_check
    import tcc_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] syndrome,
    input  logic [WORD_W-1:0] status,
    output logic              out_valid,
    output logic              out_pass
);
    decision_t                          decision;
    flags_t                             flags;
    logic [NUM_COND-1:0][NUM_FLAGS-1:0] mask;
    logic                               pass;
    logic                               unused_bits;

    assign flags       = flags_t'(status[ST_FLAG_LO +: 4]);
    assign unused_bits = ^{syndrome, status};

    tcc_source_sel #(.WORD_W(WORD_W)) u_src (
        .syndrome (syndrome),
        .status   (status),
        .decision (decision)
    );

    tcc_mask_table u_mask (
        .mask (mask)
    );

    tcc_evaluate u_eval (
        .decision (decision),
        .flags    (flags),
        .mask     (mask),
        .pass     (pass)
    );

    tcc_out_reg u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .pass      (pass),
        .out_valid (out_valid),
        .out_pass  (out_pass)
    );
endmodule

// File: rtl/tcc_checker.sv
`timescale 1ns/1ps
module tcc_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] syndrome,
    input logic [31:0] status,
    input logic        out_valid,
    input logic        out_pass
);
    logic       cond_path;
    logic [7:0] it_st;
    logic       unused_chk;

    assign cond_path  = (syndrome[31:30] == 2'b00);
    assign it_st      = {status[15:10], status[26:25]};
    assign unused_chk = ^{syndrome, status};

    p_valid_rise_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_pass));
    p_uncond_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cond_path) |=> out_pass);
    p_always_code_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond_path && syndrome[24] && syndrome[23:20] == 4'hE) |=> out_pass);
    p_it_empty_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond_path && !syndrome[24] && it_st == 8'h00) |=> out_pass);
    p_never_syn_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond_path && syndrome[24] && syndrome[23:20] == 4'hF) |=> !out_pass);
    p_never_it_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond_path && !syndrome[24] && status[15:12] == 4'hF) |=> !out_pass);
endmodule

bind trap_cond_check tcc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .syndrome  (syndrome),
    .status    (status),
    .out_valid (out_valid),
    .out_pass  (out_pass)
);

// File: tb/trap_cond_check_bench.sv
`timescale 1ns/1ps
module trap_cond_check_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] syndrome = '0;
    logic [31:0] status = '0;
    logic        out_valid;
    logic        out_pass;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    int unsigned seed = 32'h5eed_1234;

    always #2.5 clk = ~clk;

    trap_cond_check u_trap_cond_check (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .syndrome(syndrome), .status(status),
        .out_valid(out_valid), .out_pass(out_pass)
    );

    function automatic bit ref_holds(int code, bit n, bit z, bit c, bit v);
        case (code)
            0: return z;          1: return !z;
            2: return c;          3: return !c;
            4: return n;          5: return !n;
            6: return v;          7: return !v;
            8: return c && !z;    9: return !c || z;
            10: return n == v;    11: return n != v;
            12: return !z && (n == v);
            13: return z || (n != v);
            14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit ref_pass(logic [31:0] syn, logic [31:0] st);
        int code;
        logic [7:0] it;
        if (syn[31:30] != 2'b00) return 1'b1;
        if (syn[24]) begin
            code = int'(syn[23:20]);
            if (code == 14) return 1'b1;
        end else begin
            it = {st[15:10], st[26:25]};
            if (it == 8'h00) return 1'b1;
            code = int'(it[7:4]);
        end
        return ref_holds(code, st[31], st[30], st[29], st[28]);
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b syn=%h st=%h", tag, act, exp, syndrome, status);
        end
    endtask

    // drive at negedge, sample at the following negedge (one register)
    task automatic apply(string tag, logic [31:0] syn, logic [31:0] st);
        @(negedge clk);
        in_valid = 1'b1;
        syndrome = syn;
        status   = st;
        @(negedge clk);
        check({tag, " valid"}, out_valid, 1'b1);
        check(tag, out_pass, ref_pass(syn, st));
    endtask

    initial begin
        #(5.0 * 150000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] syn, st;
        logic        held;
        repeat (3) @(negedge clk);
        check("R7 reset out_valid", out_valid, 1'b0);
        check("R7 reset out_pass", out_pass, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R7 idle out_valid", out_valid, 1'b0);

        // R1: nonzero class bits with a never-pass syndrome code
        apply("R1 class01", 32'h41F0_0000, 32'h0000_0000);
        apply("R1 class10", 32'h81F0_0000, 32'hF000_F000);
        apply("R1 class11", 32'hC1F0_0000, 32'h5000_0000);
        // R2: code 0xE with every flag value
        for (int f = 0; f < 16; f++)
            apply("R2 always", 32'h01E0_0000, {4'(f), 28'h0});
        // R3/R6: syndrome path sweep
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 16; f++)
                apply(c == 15 ? "R6 syn never" : "R3 syn sweep",
                      {8'h01, 4'(c), 20'h0}, {4'(f), 28'h0});
        // R4: empty if-then state, flags that would fail EQ
        apply("R4 it empty", 32'h0000_0000, 32'h0000_0000);
        apply("R4 it empty flags", 32'h0000_0000, 32'hB1FF_03FF);
        // R5/R6: if-then path sweep; low state bits vary
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 16; f++) begin
                st = {4'(f), 1'b0, 2'(f + c), 9'h0, 4'(c), 2'(f), 10'h0};
                if (c == 0 && st[26:25] == 2'b00 && st[11:10] == 2'b00) st[25] = 1'b1;
                apply(c == 15 ? "R6 it never" : "R5 it sweep", 32'h00F0_0000 ^ 32'h00F0_0000, st);
            end
        // R8: idle cycle with inputs that would flip the result
        apply("R8 setup", 32'h01E0_0000, 32'h0);
        @(negedge clk);
        in_valid = 1'b0;
        syndrome = 32'h01F0_0000;
        @(negedge clk);
        check("R7 idle after burst", out_valid, 1'b0);
        check("R8 hold", out_pass, 1'b1);
        apply("R8 setup fail", 32'h0100_0000, 32'h0);
        @(negedge clk);
        in_valid = 1'b0;
        syndrome = 32'h4000_0000;
        held = out_pass;
        @(negedge clk);
        check("R8 hold low", out_pass, 1'b0);
        check("R8 hold same", out_pass, held);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            syn = $urandom(seed);
            seed = seed * 32'd1103515245 + 32'd12345;
            st = $urandom(seed);
            seed = seed * 32'd1103515245 + 32'd12345;
            if (syn[3:2] != 2'b11) syn[31:30] = 2'b00;
            apply("R3 R5 random", syn, st);
        end
        @(negedge clk);
        in_valid = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule